// File: doc/BRIEF.md
# PHY Management Register Bank with Per-Bit Write Rules

This block holds a small set of 16-bit management registers for an Ethernet PHY. A management station reaches it through a plain register port: one 5-bit register address shared by reads and writes, a write strobe with 16-bit write data, and a read strobe with 16-bit read data. Each bit of each register has one access class, set at elaboration time by three masks per register: a free-write mask, a clear-only mask and a guarded mask. Bits in none of the masks are read-only and keep their reset value.

Guarded bits change only on the single register write that follows the setting of an unlock flag. The flag is bit 15 of register 16, and it clears itself on that next write. Reset defaults are parameter constants. The exception is a strap field in register 16, which takes the logic levels of external strap pins sampled while reset is active. The external reset is asserted asynchronously and released synchronously inside the block.

Top module: `mreg_bank`

## Requirements
- R1: After reset, registers 0, 1, 4 and 16 read 16'h1200, 16'h7809, 16'h01E1 and 16'h3815 with bits 10:6 replaced by the strap value, and bit 15 of register 16 (the unlock flag) reads 0.
- R2: Bits 10:6 of register 16 hold the strap pins as sampled on clock edges while reset is active. Pin changes after reset release have no effect on them.
- R3: Read-only bits never change on a write: register 0 bits 15:12, register 1 bits 15:4, and register 16 bits 14 and 11.
- R4: Free-write bits take the written value: register 0 bits 7:0, all of register 4, and register 16 bits 3:0.
- R5: Clear-only bits (register 1 bits 3:0, register 16 bits 13:12) become old AND written data. Writing 1 leaves them unchanged, and they never rise after reset.
- R6: Guarded bits (register 0 bits 11:8, register 16 bits 10:4) are unchanged by any write made while the unlock flag is 0.
- R7: A write to register 16 with data bit 15 set, made while the flag is 0, sets the flag. That same write does not alter guarded bits.
- R8: While the flag is 1, the next write to any address (implemented or not) applies its data to the guarded bits of the addressed register and clears the flag, whatever its data bit 15 holds.
- R9: A read of an address other than 0, 1, 4 or 16 returns 16'h0000, and a read never changes any register or the flag.
- R10: Read data is registered. It appears on the clock edge that samples the read strobe, shows the pre-write value when a write to the same register occurs in that cycle, and holds until the next read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| strap_i | input | 5 | Strap pins sampled during reset into register 16 bits 10:6 |
| addr | input | 5 | Register address for reads and writes |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 16 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 16 | Registered read data |

## Verification
The hardest situation to reach is the single-write window after the unlock flag is set. Its edges are the setting write itself (which must not unlock), an unlocking write aimed at an unimplemented address, and a second unlock request arriving as the unlocking write. The stimulus walks through these as consecutive writes: it sets the flag, reads registers in between to show that reads do not consume the window, and then spends the window on each of those cases in turn. The strap field is covered by holding one pin pattern through reset and a different one afterwards, then rewriting the field through an unlocked write.

// File: rtl/mreg_pkg.sv
package mreg_pkg;
  localparam int DW = 16;
  localparam int AW = 5;
  typedef logic [DW-1:0] word_t;
  typedef logic [AW-1:0] addr_t;
  // location of the self-clearing unlock flag
  localparam addr_t OVR_ADDR = 5'd16;
  localparam int    OVR_BIT  = 15;
endpackage

// File: rtl/mreg_rst_sync.sv
module mreg_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/mreg_override.sv
module mreg_override (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_en,
  input  logic ctrl_hit,
  input  logic set_bit,
  output logic ovr_q
);
  logic ovr_d;

  // next state: an armed flag is consumed by any write; an idle flag
  // is armed only by a write to the control register with the bit set
  always_comb begin
    ovr_d = ovr_q;
    if (ovr_q) begin
      if (wr_en) ovr_d = 1'b0;
    end else if (wr_en && ctrl_hit && set_bit) begin
      ovr_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovr_q <= 1'b0;
    else        ovr_q <= ovr_d;
  end
endmodule

// File: rtl/mreg_slot.sv
module mreg_slot
  import mreg_pkg::*;
#(
  parameter word_t DEF       = '0,
  parameter word_t WE_M      = '0,
  parameter word_t CLR_M     = '0,
  parameter word_t PROT_M    = '0,
  parameter bit    HAS_STRAP = 1'b0,
  parameter int    STRAP_LSB = 0,
  parameter int    STRAP_W   = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  word_t              wr_data,
  input  logic               unlock,
  input  logic [STRAP_W-1:0] strap_i,
  output word_t              value
);
  localparam word_t FIELD_ONES = word_t'((1 << STRAP_W) - 1);
  localparam word_t STRAP_M    = HAS_STRAP ? (FIELD_ONES << STRAP_LSB) : '0;
  localparam word_t KEEP_M     = ~(WE_M | CLR_M | PROT_M);

  word_t q;
  word_t upd;

  // per-bit write rule
  always_comb begin
    upd = (wr_data & WE_M)
        | (value & wr_data & CLR_M)
        | (PROT_M & (unlock ? wr_data : value))
        | (value & KEEP_M);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= DEF & ~STRAP_M;
    else if (wr) q <= upd & ~STRAP_M;
  end

  if (HAS_STRAP) begin : g_strap
    logic [STRAP_W-1:0] sq;
    // sampled every edge while reset is active, then written like any bit
    always_ff @(posedge clk) begin
      if (!rst_n)  sq <= strap_i;
      else if (wr) sq <= upd[STRAP_LSB +: STRAP_W];
    end
    assign value = q | (word_t'(sq) << STRAP_LSB);
  end else begin : g_plain
    logic unused_strap;
    assign unused_strap = ^strap_i;
    assign value = q;
  end
endmodule

// File: rtl/mreg_bank.sv
module mreg_bank
  import mreg_pkg::*;
#(
  parameter int NSLOT      = 4,
  parameter logic [NSLOT-1:0][AW-1:0] SLOT_ADDR = {5'd16, 5'd4, 5'd1, 5'd0},
  parameter logic [NSLOT-1:0][DW-1:0] SLOT_DEF  = {16'h3815, 16'h01E1, 16'h7809, 16'h1200},
  parameter logic [NSLOT-1:0][DW-1:0] SLOT_WE   = {16'h000F, 16'hFFFF, 16'h0000, 16'h00FF},
  parameter logic [NSLOT-1:0][DW-1:0] SLOT_CLR  = {16'h3000, 16'h0000, 16'h000F, 16'h0000},
  parameter logic [NSLOT-1:0][DW-1:0] SLOT_PROT = {16'h07F0, 16'h0000, 16'h0000, 16'h0F00},
  parameter int STRAP_W    = 5,
  parameter int STRAP_SLOT = 3,
  parameter int STRAP_LSB  = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [AW-1:0]      addr,
  input  logic               wr_en,
  input  logic [DW-1:0]      wr_data,
  input  logic               rd_en,
  output logic [DW-1:0]      rd_data
);
  logic                     rst_sync_n;
  logic                     ovr_q;
  logic                     ctrl_hit;
  logic [NSLOT-1:0]         hit;
  logic [NSLOT-1:0][DW-1:0] slot_val;
  logic [NSLOT-1:0][DW-1:0] reg_view;
  word_t                    rd_d;

  mreg_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  assign ctrl_hit = (addr == OVR_ADDR);

  mreg_override u_ovr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .ctrl_hit (ctrl_hit),
    .set_bit  (wr_data[OVR_BIT]),
    .ovr_q    (ovr_q)
  );

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign hit[i] = (addr == SLOT_ADDR[i]);

    mreg_slot #(
      .DEF       (SLOT_DEF[i]),
      .WE_M      (SLOT_WE[i]),
      .CLR_M     (SLOT_CLR[i]),
      .PROT_M    (SLOT_PROT[i]),
      .HAS_STRAP (i == STRAP_SLOT),
      .STRAP_LSB (STRAP_LSB),
      .STRAP_W   (STRAP_W)
    ) u_slot (
      .clk     (clk),
      .rst_n   (rst_sync_n),
      .wr      (wr_en && hit[i]),
      .wr_data (wr_data),
      .unlock  (ovr_q),
      .strap_i (strap_i),
      .value   (slot_val[i])
    );

    // the control register shows the live unlock flag in its top bit
    if (SLOT_ADDR[i] == OVR_ADDR) begin : g_ctrl
      assign reg_view[i] = (slot_val[i] & ~(word_t'(1) << OVR_BIT))
                         | (word_t'(ovr_q) << OVR_BIT);
    end else begin : g_data
      assign reg_view[i] = slot_val[i];
    end
  end

  always_comb begin
    rd_d = '0;
    for (int i = 0; i < NSLOT; i++) begin
      if (hit[i]) rd_d = rd_d | reg_view[i];
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) rd_data <= '0;
    else if (rd_en)  rd_data <= rd_d;
  end
endmodule

// File: rtl/mreg_bank_chk.sv
module mreg_bank_chk
  import mreg_pkg::*;
#(
  parameter int NSLOT = 4,
  parameter logic [NSLOT-1:0][AW-1:0] SLOT_ADDR = '0,
  parameter logic [NSLOT-1:0][DW-1:0] SLOT_WE   = '0,
  parameter logic [NSLOT-1:0][DW-1:0] SLOT_CLR  = '0,
  parameter logic [NSLOT-1:0][DW-1:0] SLOT_PROT = '0
) (
  input logic                     clk,
  input logic                     rst_sync_n,
  input logic [AW-1:0]            addr,
  input logic                     wr_en,
  input logic [DW-1:0]            wr_data,
  input logic                     rd_en,
  input logic [DW-1:0]            rd_data,
  input logic                     ovr_q,
  input logic [NSLOT-1:0][DW-1:0] reg_view
);
  logic any_hit;
  always_comb begin
    any_hit = 1'b0;
    for (int i = 0; i < NSLOT; i++) if (addr == SLOT_ADDR[i]) any_hit = 1'b1;
  end

  // R7
  a_r7_ovr_set: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && addr == OVR_ADDR && wr_data[OVR_BIT] && !ovr_q) |=> ovr_q);
  // R8
  a_r8_ovr_clear: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (wr_en && ovr_q) |=> !ovr_q);
  // R9
  a_r9_ovr_no_write_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wr_en |=> $stable(ovr_q));
  a_r9_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (rd_en && !any_hit) |=> rd_data == '0);
  // R10
  a_r10_rd_hold: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !rd_en |=> $stable(rd_data));

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    localparam logic [DW-1:0] FLAG_M = (SLOT_ADDR[i] == OVR_ADDR) ? (16'h1 << OVR_BIT) : '0;
    localparam logic [DW-1:0] RO_M   = ~(SLOT_WE[i] | SLOT_CLR[i] | SLOT_PROT[i] | FLAG_M);
    // R3
    a_r3_ro_stable: assert property (@(posedge clk) disable iff (!rst_sync_n)
      $stable(reg_view[i] & RO_M));
    // R4
    a_r4_rw_take: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (wr_en && addr == SLOT_ADDR[i]) |=> (reg_view[i] & SLOT_WE[i]) == ($past(wr_data) & SLOT_WE[i]));
    // R5
    a_r5_clr_no_rise: assert property (@(posedge clk) disable iff (!rst_sync_n)
      ((reg_view[i] & ~$past(reg_view[i])) & SLOT_CLR[i]) == '0);
    // R6
    a_r6_prot_locked: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (wr_en && !ovr_q) |=> $stable(reg_view[i] & SLOT_PROT[i]));
  end
endmodule

bind mreg_bank mreg_bank_chk #(
  .NSLOT     (NSLOT),
  .SLOT_ADDR (SLOT_ADDR),
  .SLOT_WE   (SLOT_WE),
  .SLOT_CLR  (SLOT_CLR),
  .SLOT_PROT (SLOT_PROT)
) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .addr       (addr),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .ovr_q      (ovr_q),
  .reg_view   (reg_view)
);

// File: tb/tb_mreg_bank.sv
module tb_mreg_bank;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  strap_i;
  logic [4:0]  addr;
  logic        wr_en;
  logic [15:0] wr_data;
  logic        rd_en;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  mreg_bank dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .strap_i (strap_i),
    .addr    (addr),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .rd_en   (rd_en),
    .rd_data (rd_data)
  );

  task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] v);
    @(negedge clk);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rd_data;
  endtask

  task automatic rd_chk(input string req, input logic [4:0] a, input logic [15:0] exp);
    logic [15:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  // R1, R2: defaults and strap capture
  task automatic t_reset;
    chk("R1 rd_data at reset", rd_data, 16'h0000);
    rd_chk("R1 reg0 default", 5'd0, 16'h1200);
    rd_chk("R1 reg1 default", 5'd1, 16'h7809);
    rd_chk("R1 reg4 default", 5'd4, 16'h01E1);
    rd_chk("R2 reg16 default with strap 10110", 5'd16, 16'h3D95);
  endtask

  task automatic t_strap_frozen;
    strap_i = 5'b01001;
    repeat (3) @(negedge clk);
    rd_chk("R2 strap frozen after release", 5'd16, 16'h3D95);
  endtask

  // R3, R4, R5, R6 with the flag clear
  task automatic t_access_types;
    wr(5'd0, 16'hFFFF);
    rd_chk("R3 R4 R6 reg0 write ones", 5'd0, 16'h12FF);
    wr(5'd0, 16'h0000);
    rd_chk("R3 R4 R6 reg0 write zeros", 5'd0, 16'h1200);
    wr(5'd1, 16'hFFFF);
    rd_chk("R5 reg1 ones keep value", 5'd1, 16'h7809);
    wr(5'd1, 16'hFFF6);
    rd_chk("R5 reg1 clear bits 3 and 0", 5'd1, 16'h7800);
    wr(5'd1, 16'hFFFF);
    rd_chk("R5 reg1 cannot set again", 5'd1, 16'h7800);
    wr(5'd4, 16'hA5C3);
    rd_chk("R4 reg4 pattern A5C3", 5'd4, 16'hA5C3);
    wr(5'd4, 16'h0000);
    rd_chk("R4 reg4 zero", 5'd4, 16'h0000);
  endtask

  // R7, R8, R9: unlock window
  task automatic t_unlock;
    wr(5'd16, 16'hB7FF);
    rd_chk("R7 flag set, guarded bits kept", 5'd16, 16'hBD9F);
    rd_chk("R9 unimplemented addr 2 reads zero", 5'd2, 16'h0000);
    rd_chk("R9 read kept the flag", 5'd16, 16'hBD9F);
    wr(5'd0, 16'h0A55);
    rd_chk("R8 reg0 guarded bits written", 5'd0, 16'h1A55);
    rd_chk("R8 flag cleared by write", 5'd16, 16'h3D9F);
    wr(5'd0, 16'h0500);
    rd_chk("R6 reg0 guarded locked again", 5'd0, 16'h1A00);
  endtask

  task automatic t_unlock_corners;
    wr(5'd16, 16'h8000);
    rd_chk("R7 R5 flag set, clear-only cleared", 5'd16, 16'h8D90);
    wr(5'd7, 16'hFFFF);
    rd_chk("R8 write to unimplemented consumes flag", 5'd16, 16'h0D90);
    rd_chk("R9 write to addr 7 left reg0 alone", 5'd0, 16'h1A00);
    wr(5'd16, 16'h8000);
    wr(5'd16, 16'h0150);
    rd_chk("R8 R2 strap field rewritten while unlocked", 5'd16, 16'h0950);
    wr(5'd16, 16'h87F0);
    rd_chk("R7 second set keeps guarded bits", 5'd16, 16'h8950);
    wr(5'd16, 16'h8000);
    rd_chk("R8 set request during window clears flag", 5'd16, 16'h0800);
    rd_chk("R9 unimplemented addr 31 reads zero", 5'd31, 16'h0000);
  endtask

  // R10: read timing
  task automatic t_read_timing;
    logic [15:0] v;
    @(negedge clk);
    addr = 5'd4; wr_data = 16'h1234; wr_en = 1'b1; rd_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    chk("R10 read returns pre-write value", rd_data, 16'h0000);
    rd(5'd4, v);
    chk("R10 new value on next read", v, 16'h1234);
    addr = 5'd0;
    repeat (3) @(negedge clk);
    chk("R10 read data held without strobe", rd_data, 16'h1234);
  endtask

  initial begin
    rst_n = 1'b0; strap_i = 5'b10110;
    addr = '0; wr_en = 1'b0; wr_data = '0; rd_en = 1'b0;
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_strap_frozen();
    t_access_types();
    t_unlock();
    t_unlock_corners();
    t_read_timing();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule